// File: doc/BRIEF.md
# Page Program Sequencer with Completion Polling

This block sits on the host side of a byte-wide, self-timed nonvolatile memory bus. A single command names a start address, a byte count from 1 to 128, whether to put the three-write protection unlock in front of the data, and which completion test to use. The command is accepted only if every byte falls inside one 128-byte page. Before issuing the command, the host fills a local page buffer. The block then drives one write strobe per byte, with the setup, pulse and recovery spacing set by parameters. Next it reads back from the memory's own data bus until the internal programming cycle is seen to finish, and it waits a settle delay before it reports done.

There are two completion tests. In bit-7 mode, the block reads the last written address until bit 7 of the read value equals bit 7 of the last written byte. In toggle mode, it reads the same address repeatedly and finishes when two consecutive reads return the same bit 6. If polling runs longer than a parameterised limit, the block gives up and reports a timeout. All spacing values are counted in clock cycles. A bench can therefore pair the block with a memory model that uses scaled-down times.

States:
- `ST_IDLE`: waits for a command.
- `ST_SETUP`: drives address and data with the read strobe high.
- `ST_WLOW`: holds the write strobe low.
- `ST_WHIGH`: write recovery, with the read strobe still high.
- `ST_POLL_RD`: holds the read strobe low and samples.
- `ST_POLL_GAP`: read strobe high between reads.
- `ST_SETTLE`: post-completion delay.

Transitions:
- IDLE→SETUP when a command passes the page check.
- SETUP→WLOW after the setup count.
- WLOW→WHIGH after the pulse count.
- WHIGH→SETUP when more bytes remain.
- WHIGH→POLL_RD after the last byte.
- POLL_RD→SETTLE when the sample shows completion.
- POLL_RD→POLL_GAP when it does not.
- POLL_GAP→POLL_RD after the gap count.
- POLL_RD or POLL_GAP→IDLE once the poll limit is reached, with timeout.
- SETTLE→IDLE after the settle count, with done.

Top module: `pgw_poller`

## Requirements
- R1: A command with length 0, length above 128, or (start offset within page + length) above 128 raises `reject_o` for one cycle, in the cycle after the command is presented. No strobe goes low and `busy_o` stays low.
- R2: Buffer entry k is written to start address + k, for k ascending from 0. Every data write carries the same page bits, which are address bits above bit 6.
- R3: When `cmd_unlock_i` is 1, three writes come first, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, then 0xA0 to 0x5555. The data writes follow.
- R4: The write strobe stays low for at least WP_CYC cycles and high for at least WPH_CYC cycles between writes. Consecutive write-strobe falls within one command are fewer than BLC_CYC cycles apart.
- R5: The read strobe is high for at least OES_CYC cycles before every write-strobe fall. It stays high for at least OEH_CYC cycles after every write-strobe rise. The two strobes are never low together.
- R6: With `poll_sel_i` = 0, polling reads only the last written address. Completion is declared only when read bit 7 equals bit 7 of the last written byte.
- R7: With `poll_sel_i` = 1, polling reads the last written address. Completion is declared only when two consecutive reads agree in bit 6.
- R8: `done_o` pulses for one cycle exactly DW_CYC cycles after the read strobe rises at the end of the completing read.
- R9: If no completion is seen within TMO_CYC cycles of polling, `timeout_o` pulses for one cycle and `done_o` does not pulse for that command.
- R10: `busy_o` is high from acceptance until the done or timeout pulse. A command presented while busy is ignored.
- R11: After reset, all three bus strobes are high (inactive), `busy_o` is low, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_addr_i | input | ADDR_W | Start address |
| cmd_len_i | input | LEN_W | Byte count |
| cmd_unlock_i | input | 1 | Prefix the three-write unlock |
| poll_sel_i | input | 1 | 0: bit-7 compare, 1: bit-6 toggle |
| buf_we_i | input | 1 | Page buffer write enable |
| buf_idx_i | input | PG_W | Page buffer entry |
| buf_data_i | input | DATA_W | Page buffer write data |
| bus_addr_o | output | ADDR_W | Memory address |
| bus_wdata_o | output | DATA_W | Memory write data |
| bus_rdata_i | input | DATA_W | Memory read data |
| bus_sel_n_o | output | 1 | Memory select, active low |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Poll-limit pulse |
| reject_o | output | 1 | Page-range rejection pulse |

## Verification
A wrong byte index or state shows up at the memory model within one write strobe. It appears as a byte at the wrong offset, a missing unlock word, or a page change, and the model checks each strobe as it arrives. A wrong completion decision shows up at the done pulse. Done then either arrives while the model still reports programming, or it never arrives and the timeout fires instead. The settle count is measured exactly from the last read-strobe rise, so an off-by-one there is visible on the first command. Strobe spacing errors are counted on every edge by an edge monitor that is independent of the design's own counters.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WLOW,
        ST_WHIGH,
        ST_POLL_RD,
        ST_POLL_GAP,
        ST_SETTLE
    } pgw_state_t;

    typedef enum logic {
        POLL_BIT7   = 1'b0,
        POLL_TOGGLE = 1'b1
    } pgw_poll_t;

    function automatic int umax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/pgw_span_timer.sv
module pgw_span_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgw_poll_judge.sv
module pgw_poll_judge #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              mode,
    input  logic [DATA_W-1:0] rdata,
    input  logic              exp_msb,
    output logic              complete
);

    localparam int MSB = DATA_W - 1;
    localparam int TGL = DATA_W - 2;

    logic have_prev_q;
    logic prev_tgl_q;

    // bit-7 mode compares against the written value; toggle mode against the previous read
    always_comb begin
        if (mode == pgw_pkg::POLL_TOGGLE) begin
            complete = have_prev_q && (prev_tgl_q == rdata[TGL]);
        end else begin
            complete = (rdata[MSB] == exp_msb);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            prev_tgl_q  <= 1'b0;
        end else if (clear) begin
            have_prev_q <= 1'b0;
        end else if (sample) begin
            have_prev_q <= 1'b1;
            prev_tgl_q  <= rdata[TGL];
        end
    end

    // R7: a first read never ends a toggle poll, because nothing is stored to compare with
    assert_first_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear) |=> !have_prev_q);

endmodule

// File: rtl/pgw_poller.sv
module pgw_poller
    import pgw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128,
    parameter int OES_CYC    = 2,
    parameter int WP_CYC     = 13,
    parameter int WPH_CYC    = 13,
    parameter int OEH_CYC    = 2,
    parameter int RD_CYC     = 12,
    parameter int GAP_CYC    = 2,
    parameter int DW_CYC     = 1250,
    parameter int TMO_CYC    = 1500000,
    parameter int BLC_CYC    = 12000,
    parameter logic [ADDR_W-1:0] UNLK_ADDR_A = 16'h5555,
    parameter logic [ADDR_W-1:0] UNLK_ADDR_B = 16'h2AAA,
    parameter logic [DATA_W-1:0] UNLK_D1     = 8'hAA,
    parameter logic [DATA_W-1:0] UNLK_D2     = 8'h55,
    parameter logic [DATA_W-1:0] UNLK_D3     = 8'hA0,
    localparam int PG_W  = $clog2(PAGE_BYTES),
    localparam int LEN_W = PG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic              cmd_unlock_i,
    input  logic              poll_sel_i,
    input  logic              buf_we_i,
    input  logic [PG_W-1:0]   buf_idx_i,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              bus_sel_n_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              reject_o
);

    localparam int IDX_W  = LEN_W + 1;
    localparam int SPAN_W = LEN_W + 1;
    localparam int PRE_N  = 3;
    localparam int MSB    = DATA_W - 1;
    localparam int WH_CYC = umax(WPH_CYC, OEH_CYC);
    localparam int MAXT   = umax(umax(umax(OES_CYC, WP_CYC), umax(WH_CYC, RD_CYC)),
                                 umax(GAP_CYC, DW_CYC));
    localparam int TMR_W  = $clog2(MAXT + 1);
    localparam int TMO_W  = $clog2(TMO_CYC + 1);
    localparam int CHK_W  = $clog2(umax(BLC_CYC, MAXT) + 1) + 1;
    localparam logic [CHK_W-1:0] CHK_MAX = '1;

    // ---------------- state and datapath registers ----------------
    pgw_state_t        state_q, state_n;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  pre_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] base_q;
    logic              mode_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic              last_msb_q;
    logic [TMO_W-1:0]  tmo_cnt_q;
    logic              done_q, tmo_flag_q, rej_q;

    // ---------------- combinational helpers ----------------
    logic [SPAN_W-1:0] span;
    logic              len_ok;
    logic              data_phase;
    logic              last_byte;
    logic [PG_W-1:0]   byte_k;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;
    logic [DATA_W-1:0] buf_rd;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              rd_complete;
    logic              rd_sample;
    logic              poll_clear;
    logic              tmo_hit;
    logic              in_poll;

    assign span   = SPAN_W'(cmd_addr_i[PG_W-1:0]) + SPAN_W'(cmd_len_i);
    assign len_ok = (cmd_len_i != '0) && (span <= SPAN_W'(PAGE_BYTES));

    assign data_phase = (idx_q >= pre_q);
    assign byte_k     = PG_W'(idx_q - pre_q);
    assign last_byte  = (idx_q == (pre_q + IDX_W'(len_q) - IDX_W'(1)));
    assign in_poll    = (state_q == ST_POLL_RD) || (state_q == ST_POLL_GAP);
    assign tmo_hit    = (tmo_cnt_q >= TMO_W'(TMO_CYC));

    // unlock prefix words, position in the prefix selects the word
    always_comb begin
        cur_addr = base_q + ADDR_W'(byte_k);
        cur_data = buf_rd;
        if (!data_phase) begin
            unique case (idx_q[1:0])
                2'd0:    begin cur_addr = UNLK_ADDR_A; cur_data = UNLK_D1; end
                2'd1:    begin cur_addr = UNLK_ADDR_B; cur_data = UNLK_D2; end
                default: begin cur_addr = UNLK_ADDR_A; cur_data = UNLK_D3; end
            endcase
        end
    end

    // ---------------- sub-blocks ----------------
    pgw_page_buf #(
        .DEPTH  (PAGE_BYTES),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we_i),
        .wr_idx  (buf_idx_i),
        .wr_data (buf_data_i),
        .rd_idx  (byte_k),
        .rd_data (buf_rd)
    );

    pgw_span_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign rd_sample  = (state_q == ST_POLL_RD) && tmr_exp;
    assign poll_clear = (state_q == ST_WHIGH) && (state_n == ST_POLL_RD);

    pgw_poll_judge #(
        .DATA_W (DATA_W)
    ) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (poll_clear),
        .sample   (rd_sample),
        .mode     (mode_q),
        .rdata    (bus_rdata_i),
        .exp_msb  (last_msb_q),
        .complete (rd_complete)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid_i && len_ok) state_n = ST_SETUP;
            ST_SETUP:    if (tmr_exp) state_n = ST_WLOW;
            ST_WLOW:     if (tmr_exp) state_n = ST_WHIGH;
            ST_WHIGH:    if (tmr_exp) state_n = last_byte ? ST_POLL_RD : ST_SETUP;
            ST_POLL_RD: begin
                if (tmr_exp) begin
                    if (rd_complete)  state_n = ST_SETTLE;
                    else if (tmo_hit) state_n = ST_IDLE;
                    else              state_n = ST_POLL_GAP;
                end
            end
            ST_POLL_GAP: if (tmr_exp) state_n = tmo_hit ? ST_IDLE : ST_POLL_RD;
            ST_SETTLE:   if (tmr_exp) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // every transition reloads the phase timer with the new phase length minus one
    assign tmr_load = (state_n != state_q);
    always_comb begin
        unique case (state_n)
            ST_SETUP:    tmr_val = TMR_W'(OES_CYC - 1);
            ST_WLOW:     tmr_val = TMR_W'(WP_CYC - 1);
            ST_WHIGH:    tmr_val = TMR_W'(WH_CYC - 1);
            ST_POLL_RD:  tmr_val = TMR_W'(RD_CYC - 1);
            ST_POLL_GAP: tmr_val = TMR_W'(GAP_CYC - 1);
            ST_SETTLE:   tmr_val = TMR_W'(DW_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            pre_q       <= '0;
            len_q       <= '0;
            base_q      <= '0;
            mode_q      <= 1'b0;
            last_addr_q <= '0;
            last_msb_q  <= 1'b0;
            tmo_cnt_q   <= '0;
            done_q      <= 1'b0;
            tmo_flag_q  <= 1'b0;
            rej_q       <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            tmo_flag_q <= 1'b0;
            rej_q      <= 1'b0;
            if ((state_q == ST_IDLE) && cmd_valid_i) begin
                if (len_ok) begin
                    idx_q  <= '0;
                    pre_q  <= cmd_unlock_i ? IDX_W'(PRE_N) : '0;
                    len_q  <= cmd_len_i;
                    base_q <= cmd_addr_i;
                    mode_q <= poll_sel_i;
                end else begin
                    rej_q <= 1'b1;
                end
            end
            if ((state_q == ST_WHIGH) && tmr_exp) begin
                if (last_byte) begin
                    last_addr_q <= cur_addr;
                    last_msb_q  <= cur_data[MSB];
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (poll_clear) begin
                tmo_cnt_q <= '0;
            end else if (in_poll && !tmo_hit) begin
                tmo_cnt_q <= tmo_cnt_q + 1'b1;
            end
            if ((state_q == ST_SETTLE) && tmr_exp) done_q <= 1'b1;
            if (in_poll && (state_n == ST_IDLE))   tmo_flag_q <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        bus_sel_n_o = 1'b1;
        bus_rd_n_o  = 1'b1;
        bus_wr_n_o  = 1'b1;
        unique case (state_q)
            ST_SETUP, ST_WHIGH: begin
                bus_sel_n_o = 1'b0;
                bus_addr_o  = cur_addr;
                bus_wdata_o = cur_data;
            end
            ST_WLOW: begin
                bus_sel_n_o = 1'b0;
                bus_wr_n_o  = 1'b0;
                bus_addr_o  = cur_addr;
                bus_wdata_o = cur_data;
            end
            ST_POLL_RD: begin
                bus_sel_n_o = 1'b0;
                bus_rd_n_o  = 1'b0;
                bus_addr_o  = last_addr_q;
            end
            ST_POLL_GAP: begin
                bus_sel_n_o = 1'b0;
                bus_addr_o  = last_addr_q;
            end
            default: ;
        endcase
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign timeout_o = tmo_flag_q;
    assign reject_o  = rej_q;

    // ---------------- strobe spacing monitors for the assertions ----------------
    logic [CHK_W-1:0] wlo_cnt_q, whi_cnt_q, rhi_cnt_q, gap_cnt_q;
    logic             gap_live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlo_cnt_q  <= '0;
            whi_cnt_q  <= CHK_MAX;
            rhi_cnt_q  <= CHK_MAX;
            gap_cnt_q  <= '0;
            gap_live_q <= 1'b0;
        end else begin
            wlo_cnt_q <= !bus_wr_n_o ? ((wlo_cnt_q != CHK_MAX) ? wlo_cnt_q + 1'b1 : wlo_cnt_q) : '0;
            whi_cnt_q <=  bus_wr_n_o ? ((whi_cnt_q != CHK_MAX) ? whi_cnt_q + 1'b1 : whi_cnt_q) : '0;
            rhi_cnt_q <=  bus_rd_n_o ? ((rhi_cnt_q != CHK_MAX) ? rhi_cnt_q + 1'b1 : rhi_cnt_q) : '0;
            if (!busy_o) begin
                gap_live_q <= 1'b0;
                gap_cnt_q  <= '0;
            end else if (bus_wr_n_o == 1'b0 && wlo_cnt_q == '0) begin
                gap_live_q <= 1'b1;
                gap_cnt_q  <= '0;
            end else if (gap_cnt_q != CHK_MAX) begin
                gap_cnt_q  <= gap_cnt_q + 1'b1;
            end
        end
    end

    assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> (bus_wr_n_o && bus_rd_n_o && !busy_o));

    assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_wr_n_o) && data_phase) |-> (bus_addr_o[ADDR_W-1:PG_W] == base_q[ADDR_W-1:PG_W]));

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n_o) |-> (wlo_cnt_q >= CHK_W'(WP_CYC)));

    assert_we_recovery_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n_o) |-> (whi_cnt_q >= CHK_W'(WPH_CYC)));

    assert_load_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_wr_n_o) && gap_live_q) |-> (gap_cnt_q < CHK_W'(BLC_CYC)));

    assert_oe_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n_o) |-> (rhi_cnt_q >= CHK_W'(OES_CYC)));

    assert_oe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n_o) |-> (whi_cnt_q >= CHK_W'(OEH_CYC)));

    assert_no_contend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_wr_n_o && !bus_rd_n_o));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    assert_flags_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o || reject_o) |-> !busy_o);

endmodule

// File: tb/pgw_poller_tb.sv
module pgw_poller_tb;

    localparam int OES = 2, WP = 3, WPH = 3, OEH = 2, RDC = 2, GAP = 2, DW = 5;
    localparam int TMO = 3000, BLC = 20, TWC = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_len = '0;
    logic        cmd_unlock = 1'b0;
    logic        poll_sel = 1'b0;
    logic        buf_we = 1'b0;
    logic [6:0]  buf_idx = '0;
    logic [7:0]  buf_data = '0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_sel_n, bus_rd_n, bus_wr_n, busy, done, tmo, rej;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    pgw_poller #(
        .OES_CYC(OES), .WP_CYC(WP), .WPH_CYC(WPH), .OEH_CYC(OEH), .RD_CYC(RDC),
        .GAP_CYC(GAP), .DW_CYC(DW), .TMO_CYC(TMO), .BLC_CYC(BLC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr),
        .cmd_len_i(cmd_len), .cmd_unlock_i(cmd_unlock), .poll_sel_i(poll_sel),
        .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_data_i(buf_data),
        .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
        .bus_sel_n_o(bus_sel_n), .bus_rd_n_o(bus_rd_n), .bus_wr_n_o(bus_wr_n),
        .busy_o(busy), .done_o(done), .timeout_o(tmo), .reject_o(rej)
    );

    // ---------------- memory model and edge monitor ----------------
    logic [7:0]  m_arr [128];
    logic [7:0]  ref_d [128];
    logic [15:0] log_a [3];
    logic [7:0]  log_d [3];
    logic [8:0]  m_page;
    logic [15:0] m_last_a, m_next;
    logic [7:0]  m_last_d;
    logic        m_loading = 0, m_stuck = 0, m_tog = 0, m_page_set = 0;
    int m_prog = 0, m_blc = 0, m_stored = 0, m_nlog = 0, m_uk = 0, m_unl = 0;
    int order_bad = 0, page_bad = 0, rdaddr_bad = 0, we_bad = 0, oe_bad = 0;
    int t_wlo = 0, t_whi = 1000, t_rhi = 1000, t_gap = 0, n_done = 0, n_falls = 0;
    int dwc = 0, dw_meas = -1;
    bit gap_live = 0, busy_at_done = 0;
    logic pw = 1, pr = 1;

    wire m_busy = m_loading || (m_prog != 0);

    always_comb begin
        if (m_busy)                       bus_rdata = {~m_last_d[7], m_tog, m_last_d[5:0]};
        else if (bus_addr[15:7] == m_page) bus_rdata = m_arr[bus_addr[6:0]];
        else                              bus_rdata = 8'hFF;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit fell;
            fell = pw && !bus_wr_n;
            if (fell) begin
                n_falls++;
                if (t_whi < WPH) we_bad++;
                if (t_rhi < OES) oe_bad++;
                if (gap_live && t_gap >= BLC) we_bad++;
                gap_live = 1; t_gap = 0;
                if (m_nlog < 3) begin log_a[m_nlog] = bus_addr; log_d[m_nlog] = bus_wdata; m_nlog++; end
                if (m_uk == 0 && bus_addr == 16'h5555 && bus_wdata == 8'hAA) m_uk = 1;
                else if (m_uk == 1 && bus_addr == 16'h2AAA && bus_wdata == 8'h55) m_uk = 2;
                else if (m_uk == 2 && bus_addr == 16'h5555 && bus_wdata == 8'hA0) begin m_uk = 0; m_unl++; end
                else begin
                    m_uk = 0;
                    if (!m_page_set) begin m_page = bus_addr[15:7]; m_page_set = 1; end
                    else if (bus_addr[15:7] != m_page) page_bad++;
                    if (bus_addr != m_next) order_bad++;
                    m_next = bus_addr + 16'd1;
                    m_arr[bus_addr[6:0]] = bus_wdata;
                    m_last_a = bus_addr; m_last_d = bus_wdata;
                    m_stored++; m_loading = 1; m_blc = 0;
                end
            end else begin
                t_gap++;
                if (m_loading) begin
                    m_blc++;
                    if (m_blc > BLC) begin m_loading = 0; m_prog = TWC; end
                end
            end
            if (m_prog != 0 && !m_stuck) m_prog--;
            if (!bus_wr_n) t_wlo = pw ? 1 : t_wlo + 1;
            else begin
                if (!pw && t_wlo < WP) we_bad++;
                if (!pw) t_whi = 1; else t_whi++;
            end
            if (pr && !bus_rd_n) begin
                if (t_whi < OEH) oe_bad++;
                if (!bus_wr_n) oe_bad++;
                if (bus_addr != m_last_a) rdaddr_bad++;
                if (m_busy) m_tog = ~m_tog;
            end
            if (bus_rd_n) t_rhi++; else t_rhi = 0;
            if (!pr && bus_rd_n) dwc = 0; else dwc++;
            if (done) begin n_done++; dw_meas = dwc; busy_at_done = m_busy; end
            pw = bus_wr_n; pr = bus_rd_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_reject(input logic [15:0] a, input int len);
        return (len == 0) || (len > 128) || (int'(a[6:0]) + len > 128);
    endfunction

    function automatic logic [15:0] exp_pre_addr(input int k);
        return (k == 1) ? 16'h2AAA : 16'h5555;
    endfunction

    function automatic logic [7:0] exp_pre_data(input int k);
        return (k == 0) ? 8'hAA : ((k == 1) ? 8'h55 : 8'hA0);
    endfunction

    task automatic model_clear(input logic [15:0] a, input bit stuck);
        m_stored = 0; m_nlog = 0; m_uk = 0; m_unl = 0; m_page_set = 0; m_page = '1;
        m_loading = 0; m_prog = 0; m_stuck = stuck; m_next = a; m_last_a = a; m_last_d = '0;
        order_bad = 0; page_bad = 0; rdaddr_bad = 0; we_bad = 0; oe_bad = 0;
        n_done = 0; n_falls = 0; dw_meas = -1; gap_live = 0;
    endtask

    // result: 0 done, 1 timeout, 2 reject, 3 hang
    task automatic run_cmd(input logic [15:0] a, input int len, input bit unl, input bit md,
                           input bit stuck, input bit poke, output int res);
        int lim;
        for (int i = 0; i < 128; i++) begin
            ref_d[i] = 8'($urandom);
            @(negedge clk);
            buf_we = 1; buf_idx = 7'(i); buf_data = ref_d[i];
        end
        @(negedge clk);
        buf_we = 0;
        model_clear(a, stuck);
        cmd_valid = 1; cmd_addr = a; cmd_len = 8'(len); cmd_unlock = unl; poll_sel = md;
        @(negedge clk);
        cmd_valid = 0;
        res = 3;
        lim = 0;
        while (lim < 20000) begin
            if (done) begin res = 0; break; end
            if (tmo)  begin res = 1; break; end
            if (rej)  begin res = 2; break; end
            if (poke && lim == 6) begin
                cmd_valid = 1; cmd_addr = a ^ 16'h0100; cmd_len = 8'd2;
            end else cmd_valid = 0;
            @(negedge clk);
            lim++;
        end
        cmd_valid = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_good(input logic [15:0] a, input int len, input bit unl, input bit md, input int res);
        int mism = 0;
        if (md) check(res == 0, "R7 toggle poll done", res, 0);
        else    check(res == 0, "R6 bit7 poll done", res, 0);
        check(busy_at_done == 0, md ? "R7 done only after programming" : "R6 done only after programming",
              busy_at_done, 0);
        check(rdaddr_bad == 0, "R6 poll reads last address", rdaddr_bad, 0);
        check(dw_meas == DW, "R8 settle delay", dw_meas, DW);
        check(m_stored == len, "R2 bytes stored", m_stored, len);
        for (int i = 0; i < len; i++) if (m_arr[7'(int'(a[6:0]) + i)] !== ref_d[i]) mism++;
        check(mism == 0, "R2 byte contents", mism, 0);
        check(order_bad == 0 && page_bad == 0, "R2 ascending in one page", order_bad + page_bad, 0);
        check(m_unl == (unl ? 1 : 0), "R3 unlock count", m_unl, unl ? 1 : 0);
        if (unl) for (int k = 0; k < 3; k++)
            check(log_a[k] == exp_pre_addr(k) && log_d[k] == exp_pre_data(k), "R3 unlock word",
                  int'({log_a[k], log_d[k]}), int'({exp_pre_addr(k), exp_pre_data(k)}));
        check(we_bad == 0, "R4 write strobe spacing", we_bad, 0);
        check(oe_bad == 0, "R5 read strobe spacing", oe_bad, 0);
        check(n_done == 1 && !busy, "R10 single done then idle", n_done, 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int res;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(bus_wr_n && bus_rd_n && bus_sel_n, "R11 bus idle in reset", {bus_wr_n, bus_rd_n, bus_sel_n}, 7);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done && !tmo && !rej, "R11 flags clear after reset", {busy, done, tmo, rej}, 0);

        // R1 rejects
        run_cmd(16'h0300, 0, 0, 0, 0, 0, res);
        check(res == 2 && exp_reject(16'h0300, 0), "R1 zero length", res, 2);
        check(n_falls == 0, "R1 no bus activity", n_falls, 0);
        run_cmd(16'h0400, 129, 0, 0, 0, 0, res);
        check(res == 2, "R1 length above page", res, 2);
        run_cmd(16'h047A, 7, 1, 1, 0, 0, res);
        check(res == 2 && exp_reject(16'h047A, 7), "R1 crossing page", res, 2);
        check(n_falls == 0, "R1 no bus activity on crossing", n_falls, 0);

        // boundaries
        run_cmd(16'h1200, 128, 0, 0, 0, 0, res);
        check_good(16'h1200, 128, 0, 0, res);
        run_cmd(16'h347F, 1, 1, 1, 0, 0, res);
        check_good(16'h347F, 1, 1, 1, res);

        // random mix
        for (int n = 0; n < 8; n++) begin
            int len, off;
            logic [15:0] a;
            bit unl, md;
            len = $urandom_range(1, 128);
            off = $urandom_range(0, 128 - len);
            a   = {9'($urandom), 7'(off)};
            unl = 1'($urandom);
            md  = 1'($urandom);
            run_cmd(a, len, unl, md, 0, 0, res);
            check_good(a, len, unl, md, res);
        end

        // R10 command while busy is ignored
        run_cmd(16'h5600, 6, 0, 1, 0, 1, res);
        check_good(16'h5600, 6, 0, 1, res);

        // R9 timeouts in both modes
        run_cmd(16'h7700, 3, 0, 0, 1, 0, res);
        check(res == 1 && n_done == 0, "R9 timeout bit7", res, 1);
        run_cmd(16'h7800, 2, 1, 1, 1, 0, res);
        check(res == 1 && n_done == 0, "R9 timeout toggle", res, 1);
        check(!busy, "R10 idle after timeout", busy, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule